// File: doc/BRIEF.md
# Serial Programming Entry Sequencer

This host-side block walks a target device into its serial program/verify mode by driving three of its pins: the target reset line, a serial clock and a serial data line with an output enable. Once enabled and given a start request, it pulses the reset line high and then low, waits a lead interval, shifts out a fixed 32-bit entry key, waits a short tail, then raises the reset line and keeps it high. After a settling interval it reports ready, and the host may begin sending programming traffic.

Every interval is a parameter counted in system clock cycles. Dropping the enable input at any time sends the block back to idle with the reset line low. The analog programming voltage, the commands sent after entry and any readback from the target are handled elsewhere.

Top module: `serprog_entry`

## Requirements
- R1: During and after reset, with no start accepted, every output is low: reset line, serial clock, serial data, data enable, busy and ready.
- R2: When a start is sampled with enable high in idle, the reset line goes high in the next cycle and stays high for PULSE_CYC cycles, then goes low.
- R3: For LEAD_CYC cycles after the reset line falls, the serial clock stays low and the data enable stays low.
- R4: In the key phase the serial clock makes exactly 32 pulses, each bit HALF_CYC cycles low followed by HALF_CYC cycles high, so the phase lasts 64*HALF_CYC cycles; outside it the serial clock stays low.
- R5: The data bits sampled at the serial clock rising edges form 32'h4D434851, bit 31 first, and the data line does not change while the serial clock is high.
- R6: After the last key bit the reset line stays low for TAIL_CYC cycles, then goes high and stays high until enable drops.
- R7: Ready rises SETTLE_CYC cycles after the reset line rises and holds; busy is high from the first cycle after start until the cycle before ready and is never high together with ready.
- R8: When enable is sampled low, in the next cycle the reset line, serial clock, data, data enable, busy and ready are all low, and a later start runs the sequence from the beginning.
- R9: A start is ignored while enable is low, while busy, and while ready.
- R10: Outside the key phase the data enable is low and the serial data output is driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enable; low forces idle |
| start_i | input | 1 | Start request, sampled in idle |
| rst_line_o | output | 1 | Target reset line level |
| ser_clk_o | output | 1 | Serial clock to target |
| ser_dat_o | output | 1 | Serial data to target |
| ser_dat_oe_o | output | 1 | Serial data output enable |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | Target in program/verify mode |

## Verification
A wrong phase state shows up on the reset line or the data enable in the very cycle it occurs, since both decode the state register directly, so phase boundaries are checked at their exact cycle offsets from start. A wrong bit counter or shift register state shows as a missing or extra serial clock pulse or a wrong key bit, which the bench detects by rebuilding the key from the rising edges of the serial clock. A stale interval counter shifts every later boundary, and the ready cycle catches it.

// File: rtl/serprog_entry_pkg.sv
package serprog_entry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PULSE, ST_LEAD, ST_KEY, ST_TAIL, ST_SETTLE, ST_READY
  } seq_state_e;

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/serprog_interval_timer.sv
module serprog_interval_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/serprog_key_shifter.sv
module serprog_key_shifter #(
  parameter int unsigned  KEY_W    = 32,
  parameter logic [KEY_W-1:0] KEY  = 32'h4D43_4851,
  parameter int unsigned  HALF_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic clk_o,
  output logic dat_o,
  output logic done_o
);
  localparam int unsigned HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int unsigned BW = (KEY_W > 1) ? $clog2(KEY_W) : 1;

  logic [HW-1:0]    hc_q;
  logic [BW-1:0]    bit_q;
  logic [KEY_W-1:0] sh_q;
  logic             clk_q;
  logic             half_end;

  assign half_end = (hc_q == HW'(HALF_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q  <= '0;
      bit_q <= '0;
      sh_q  <= KEY;
      clk_q <= 1'b0;
    end else if (!run_i) begin
      hc_q  <= '0;
      bit_q <= '0;
      sh_q  <= KEY;
      clk_q <= 1'b0;
    end else if (half_end) begin
      hc_q  <= '0;
      clk_q <= !clk_q;
      if (clk_q) begin
        // falling edge: advance to next bit while clock goes low
        sh_q  <= sh_q << 1;
        bit_q <= bit_q + 1'b1;
      end
    end else begin
      hc_q <= hc_q + 1'b1;
    end
  end

  assign clk_o  = clk_q;
  assign dat_o  = sh_q[KEY_W-1];
  assign done_o = run_i && clk_q && half_end && (bit_q == BW'(KEY_W - 1));

  assert_dat_stable_hi_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && clk_q && $past(clk_q)) |-> $stable(dat_o));

  assert_clk_idle_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_i) |-> !clk_q);
endmodule

// File: rtl/serprog_entry.sv
module serprog_entry
  import serprog_entry_pkg::*;
#(
  parameter int unsigned  KEY_W      = 32,
  parameter logic [KEY_W-1:0] KEY    = 32'h4D43_4851,
  parameter int unsigned  PULSE_CYC  = 4,
  parameter int unsigned  LEAD_CYC   = 6,
  parameter int unsigned  HALF_CYC   = 2,
  parameter int unsigned  TAIL_CYC   = 3,
  parameter int unsigned  SETTLE_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_i,
  output logic rst_line_o,
  output logic ser_clk_o,
  output logic ser_dat_o,
  output logic ser_dat_oe_o,
  output logic busy_o,
  output logic ready_o
);
  localparam int unsigned MAXC = max4(PULSE_CYC, LEAD_CYC, TAIL_CYC, SETTLE_CYC);
  localparam int unsigned CW   = $clog2(MAXC + 1);

  seq_state_e     state_q, state_d;
  logic           ld;
  logic [CW-1:0]  ld_val;
  logic           tmr_zero;
  logic           in_key;
  logic           key_clk, key_dat, key_done;

  serprog_interval_timer #(.W(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld),
    .load_val_i (ld_val),
    .zero_o     (tmr_zero)
  );

  assign in_key = (state_q == ST_KEY);

  serprog_key_shifter #(.KEY_W(KEY_W), .KEY(KEY), .HALF_CYC(HALF_CYC)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (in_key),
    .clk_o  (key_clk),
    .dat_o  (key_dat),
    .done_o (key_done)
  );

  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = '0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_PULSE; ld = 1'b1; ld_val = CW'(PULSE_CYC - 1);
      end
      ST_PULSE: if (tmr_zero) begin
        state_d = ST_LEAD; ld = 1'b1; ld_val = CW'(LEAD_CYC - 1);
      end
      ST_LEAD:  if (tmr_zero) state_d = ST_KEY;
      ST_KEY: if (key_done) begin
        state_d = ST_TAIL; ld = 1'b1; ld_val = CW'(TAIL_CYC - 1);
      end
      ST_TAIL: if (tmr_zero) begin
        state_d = ST_SETTLE; ld = 1'b1; ld_val = CW'(SETTLE_CYC - 1);
      end
      ST_SETTLE: if (tmr_zero) state_d = ST_READY;
      ST_READY:  state_d = ST_READY;
      default:   state_d = ST_IDLE;
    endcase
    if (!en_i) begin
      state_d = ST_IDLE;
      ld      = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign rst_line_o   = (state_q == ST_PULSE) || (state_q == ST_SETTLE) ||
                        (state_q == ST_READY);
  assign ser_clk_o    = in_key & key_clk;
  assign ser_dat_o    = in_key & key_dat;
  assign ser_dat_oe_o = in_key;
  assign busy_o       = (state_q != ST_IDLE) && (state_q != ST_READY);
  assign ready_o      = (state_q == ST_READY);

  assert_ready_busy_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && busy_o));

  assert_ready_line_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> rst_line_o);

  assert_en_low_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!rst_line_o && !ser_dat_oe_o && !busy_o && !ready_o));

  assert_oe_line_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_dat_oe_o |-> !rst_line_o);

  assert_clk_needs_oe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_clk_o |-> ser_dat_oe_o);

  assert_ready_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && en_i) |=> ready_o);
endmodule

// File: tb/serprog_entry_bench.sv
module serprog_entry_bench;
  localparam int unsigned NS = 170;
  localparam logic [31:0] KEY_EXP = 32'h4D43_4851;
  // {t[15:0], line, clk, dat, oe, busy, ready}
  localparam int unsigned NV = 13;
  localparam logic [21:0] VEC [NV] = '{
    {16'd0,   6'b100010}, {16'd3,   6'b100010}, {16'd4,   6'b000010},
    {16'd9,   6'b000010}, {16'd10,  6'b000110}, {16'd12,  6'b010110},
    {16'd14,  6'b001110}, {16'd137, 6'b011110}, {16'd138, 6'b000010},
    {16'd140, 6'b000010}, {16'd141, 6'b100010}, {16'd148, 6'b100010},
    {16'd149, 6'b100001}
  };

  logic clk = 1'b0;
  logic rst_n, en, start;
  logic line, sclk, sdat, soe, busy, ready;
  int checks = 0, fails = 0;
  logic [5:0] smp [NS];

  always #2 clk = ~clk;

  serprog_entry u_serprog_entry (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .start_i(start),
    .rst_line_o(line), .ser_clk_o(sclk), .ser_dat_o(sdat),
    .ser_dat_oe_o(soe), .busy_o(busy), .ready_o(ready)
  );

  function automatic string req_of(int t);
    if (t < 4)   return "R2";
    if (t < 10)  return "R3";
    if (t < 138) return "R4/R5";
    if (t < 141) return "R6";
    return "R7";
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] pins();
    return {line, sclk, sdat, soe, busy, ready};
  endfunction

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int rises, bad_stable;
    logic [31:0] key;
    rst_n = 1'b0; en = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset", pins(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: start with enable low
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R9 start while disabled", pins(), 0);
    en = 1'b1;
    @(negedge clk);
    chk("R1 idle enabled", pins(), 0);

    // main run, t counted from the edge that samples start
    start = 1'b1;
    for (int t = 0; t < NS; t++) begin
      @(negedge clk);
      smp[t] = pins();
      start = (t == 50) || (t == 152); // R9: ignored while busy and while ready
    end
    start = 1'b0;

    for (int i = 0; i < NV; i++) begin
      int t;
      t = int'(VEC[i][21:6]);
      chk(req_of(t), smp[t], VEC[i][5:0]);
    end

    rises = 0; bad_stable = 0; key = '0;
    for (int t = 1; t < NS; t++) begin
      if (smp[t][4] && !smp[t-1][4]) begin
        rises++;
        key = {key[30:0], smp[t][3]};
      end
      if (smp[t][4] && smp[t-1][4] && (smp[t][3] != smp[t-1][3])) bad_stable++;
    end
    chk("R4 pulse count", rises, 32);
    chk("R5 key value", key, KEY_EXP);
    chk("R5 data stable while clk high", bad_stable, 0);
    chk("R7 ready held", smp[NS-1], 6'b100001);
    chk("R9 start ignored when ready", smp[155], 6'b100001);
    chk("R10 data low outside key", int'(smp[5][3] | smp[139][3] | smp[160][3]), 0);

    // R8: drop enable in the middle of the key phase
    en = 1'b0;
    @(negedge clk);
    chk("R8 disable from ready", pins(), 0);
    en = 1'b1;
    start = 1'b1;
    for (int t = 0; t < 31; t++) begin
      @(negedge clk);
      start = 1'b0;
      if (t == 30) begin
        chk("R8 mid-key in key", int'(soe), 1);
        en = 1'b0;
      end
    end
    @(negedge clk);
    chk("R8 mid-key abort", pins(), 0);
    en = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 restart pulse", pins(), 6'b100010);
    for (int t = 1; t < 11; t++) @(negedge clk);
    chk("R8 restart key first bit", pins(), 6'b000110);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule